// File: doc/BRIEF.md
# Colour Lookup Table with Byte-Wide Register Access

This block holds a 256-entry colour table. Each entry has three 6-bit components: red, green and blue. Software reaches the table through four byte-wide registers on a simple synchronous strobe bus. One register is the data port, and it is shared by all three components. A hidden three-state phase steps each access through red, green and blue. After the blue access the entry number moves on by one. Writes and reads each have their own entry pointer and their own phase, so a write sequence and a read-back sequence do not disturb each other.

A second, independent port serves the display pipeline. Every cycle it takes an 8-bit pixel code and ANDs it with the pixel mask register. It returns the stored 18-bit colour one clock later. Writes to the table are staged. A new colour becomes visible only when the blue component of its triplet arrives.

Top module: `pal_regport`

## Requirements
- R1: After reset, the write pointer reads 0, the read pointer reads 0, the pixel mask reads 0xFF, and both phases are at red.
- R2: Register offsets on `bus_addr` are: 0 pixel mask, 1 read pointer, 2 write pointer, 3 colour data. A data write stores `bus_wdata[5:0]` as the component; bits 7:6 are discarded.
- R3: A write to the write pointer sets the entry that the next data write goes to, and returns the write phase to red, even in the middle of a triplet.
- R4: Data writes fill red, then green, then blue of the current write entry. The entry is updated only on the blue write, with all three components at once. An abandoned triplet (fewer than three writes before the write pointer is reloaded) leaves the entry unchanged.
- R5: After each blue write the write pointer advances by one and wraps from 255 to 0. A read of it returns the current value, so N full triplets written from entry 0 leave it at N mod 256.
- R6: A write to the read pointer sets the entry to read and returns the read phase to red. Successive data reads return red, green and blue of that entry, and then the read pointer advances by one.
- R7: A read of any register presents its value on `bus_rdata` from the clock edge after the strobe until the next read strobe. A data read returns the component in bits 5:0 with bits 7:6 at zero.
- R8: The pixel mask register can be written and read back. The colour table is looked up at `pix_idx & mask`, so a mask of 0xFF passes the pixel code unchanged.
- R9: `pix_rgb` carries red in bits 17:12, green in 11:6 and blue in 5:0, one clock after `pix_idx` is presented. If a blue write commits the same entry in that cycle, the old colour is returned, and the new colour from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid from the edge after `bus_rd` |
| pix_idx | input | 8 | Pixel code for lookup |
| pix_rgb | output | 18 | Looked-up colour, one cycle after `pix_idx` |

## Verification
The display lookup and the blue commit of a register write can hit the same table entry on the same clock edge. The bench provokes this by staging red and green for an entry. It then issues the blue write in the same cycle that the pixel port presents that entry's code. The scoreboard expects the colour held before the write for that lookup, and the freshly written colour for the lookup one cycle later. Masked lookups on entries with distinct contents confirm that the port decodes the AND of code and mask.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Component phase shared by the write and read cursors
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  // Register offsets on the strobe bus
  localparam logic [1:0] REG_MASK = 2'd0;
  localparam logic [1:0] REG_RIDX = 2'd1;
  localparam logic [1:0] REG_WIDX = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;
endpackage

// File: rtl/pal_cursor.sv
// Entry pointer with a modulo-3 component phase.
module pal_cursor
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_t           phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      unique case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  // A reload sets the entry and restarts at red (write and read pointers: R3, R6)
  p_cursor_load_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (idx == $past(load_val)) && (phase == PH_RED));

  // Third access moves to the next entry, wrapping at the top
  p_cursor_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && step && phase == PH_BLU) |=> (idx == $past(idx) + 1'b1) && (phase == PH_RED));

  // Without an access the cursor holds
  p_cursor_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(idx) && $stable(phase));

endmodule

// File: rtl/pal_ram.sv
// Colour storage: one write port, two synchronous read ports, read-first.
module pal_ram #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (a_en) a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/pal_regport.sv
module pal_regport
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);

  localparam int RGB_W = 3 * COMP_W;

  // Strobe decode
  logic wr_widx, wr_ridx, wr_mask, wr_data, rd_data;
  assign wr_widx = bus_wr && (bus_addr == REG_WIDX);
  assign wr_ridx = bus_wr && (bus_addr == REG_RIDX);
  assign wr_mask = bus_wr && (bus_addr == REG_MASK);
  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign rd_data = bus_rd && (bus_addr == REG_DATA);

  // Write and read cursors
  logic [IDX_W-1:0] w_idx, r_idx;
  phase_t           w_phase, r_phase;

  pal_cursor #(.IDX_W(IDX_W)) u_wcur (
    .clk(clk), .rst(rst), .load(wr_widx), .load_val(bus_wdata[IDX_W-1:0]),
    .step(wr_data), .idx(w_idx), .phase(w_phase)
  );

  pal_cursor #(.IDX_W(IDX_W)) u_rcur (
    .clk(clk), .rst(rst), .load(wr_ridx), .load_val(bus_wdata[IDX_W-1:0]),
    .step(rd_data), .idx(r_idx), .phase(r_phase)
  );

  // Staging of red and green until blue arrives
  logic [COMP_W-1:0] wr_comp, st_r, st_g;
  assign wr_comp = bus_wdata[COMP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_r <= '0;
      st_g <= '0;
    end else if (wr_data) begin
      if (w_phase == PH_RED) st_r <= wr_comp;
      if (w_phase == PH_GRN) st_g <= wr_comp;
    end
  end

  logic             commit;
  logic [RGB_W-1:0] commit_rgb;
  assign commit     = wr_data && (w_phase == PH_BLU);
  assign commit_rgb = {st_r, st_g, wr_comp};

  // Pixel mask
  logic [IDX_W-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (wr_mask) mask_q <= bus_wdata[IDX_W-1:0];
  end

  // Storage
  logic [RGB_W-1:0] bus_q;

  pal_ram #(.AW(IDX_W), .DW(RGB_W)) u_ram (
    .clk(clk), .we(commit), .waddr(w_idx), .wdata(commit_rgb),
    .a_en(rd_data), .a_addr(r_idx), .a_q(bus_q),
    .b_addr(pix_idx & mask_q), .b_q(pix_rgb)
  );

  // Component slices of the bus-side read word, red first
  logic [COMP_W-1:0] q_comp [3];
  for (genvar k = 0; k < 3; k++) begin : g_slice
    assign q_comp[k] = bus_q[(2-k)*COMP_W +: COMP_W];
  end

  // Read-data path: register values captured at the strobe
  logic [BUS_W-1:0] reg_q;
  logic             sel_data_q;
  phase_t           ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      sel_data_q <= 1'b0;
      ph_q       <= PH_RED;
    end else if (bus_rd) begin
      sel_data_q <= (bus_addr == REG_DATA);
      ph_q       <= r_phase;
      unique case (bus_addr)
        REG_MASK: reg_q <= BUS_W'(mask_q);
        REG_RIDX: reg_q <= BUS_W'(r_idx);
        REG_WIDX: reg_q <= BUS_W'(w_idx);
        default:  reg_q <= '0;
      endcase
    end
  end

  logic [COMP_W-1:0] sel_comp;
  always_comb begin
    unique case (ph_q)
      PH_RED:  sel_comp = q_comp[0];
      PH_GRN:  sel_comp = q_comp[1];
      default: sel_comp = q_comp[2];
    endcase
  end

  assign bus_rdata = sel_data_q ? BUS_W'(sel_comp) : reg_q;

  // Upper data bits read as zero after a data read
  p_rdata_hi_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> (bus_rdata[BUS_W-1:COMP_W] == '0));

  // Mask leaves reset fully open
  p_mask_open_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_q == '1));

endmodule

// File: tb/sim_pal_regport.sv
`timescale 1ns/1ps
module sim_pal_regport;

  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_RIDX = 2'd1;
  localparam logic [1:0] A_WIDX = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [17:0] pix_rgb;
  logic        pix_chk = 1'b0;

  always #2.5 clk = ~clk;

  pal_regport u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  typedef struct {
    logic [17:0] exp;
    string       tag;
  } exp_t;

  exp_t bus_q[$];
  exp_t pix_q[$];
  exp_t e;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model built from the requirements
  logic [17:0] m_pal [256];
  int          w_i = 0, w_p = 0, r_i = 0, r_p = 0;
  logic [5:0]  m_r = '0, m_g = '0;
  logic [7:0]  m_mask = 8'hFF;

  logic bus_pend = 1'b0, pix_pend = 1'b0;
  always @(posedge clk) begin
    bus_pend <= bus_rd && !rst;
    pix_pend <= pix_chk && !rst;
  end

  // Monitor
  always @(negedge clk) begin
    if (bus_pend) begin
      if (bus_q.size() == 0) begin
        n_bad++;
        $display("FAIL bus: unexpected read result %h, expected none", bus_rdata);
      end else begin
        e = bus_q.pop_front();
        n_chk++;
        if (bus_rdata !== e.exp[7:0]) begin
          n_bad++;
          $display("FAIL %s: bus_rdata actual %h expected %h", e.tag, bus_rdata, e.exp[7:0]);
        end
      end
    end
    if (pix_pend) begin
      if (pix_q.size() == 0) begin
        n_bad++;
        $display("FAIL pix: unexpected lookup %h, expected none", pix_rgb);
      end else begin
        e = pix_q.pop_front();
        n_chk++;
        if (pix_rgb !== e.exp) begin
          n_bad++;
          $display("FAIL %s: pix_rgb actual %h expected %h", e.tag, pix_rgb, e.exp);
        end
      end
    end
  end

  // Driver: one cycle of stimulus plus expectation push
  task automatic step(input bit bw, input bit br, input logic [1:0] a, input logic [7:0] d,
                      input bit pc, input logic [7:0] pidx, input string tag);
    exp_t x;
    logic [5:0] c;
    @(negedge clk);
    bus_wr = bw; bus_rd = br; bus_addr = a; bus_wdata = d;
    pix_chk = pc; pix_idx = pidx;
    x.tag = tag;
    if (pc) begin
      x.exp = m_pal[pidx & m_mask];
      pix_q.push_back(x);
    end
    if (br) begin
      case (a)
        A_MASK: x.exp = {10'b0, m_mask};
        A_RIDX: x.exp = 18'(r_i);
        A_WIDX: x.exp = 18'(w_i);
        default: begin
          x.exp = {12'b0, m_pal[r_i][(2-r_p)*6 +: 6]};
          if (r_p == 2) begin r_p = 0; r_i = (r_i + 1) % 256; end
          else r_p++;
        end
      endcase
      bus_q.push_back(x);
    end
    if (bw) begin
      case (a)
        A_MASK: m_mask = d;
        A_RIDX: begin r_i = d; r_p = 0; end
        A_WIDX: begin w_i = d; w_p = 0; end
        default: begin
          c = d[5:0];
          if (w_p == 0) begin m_r = c; w_p = 1; end
          else if (w_p == 1) begin m_g = c; w_p = 2; end
          else begin
            m_pal[w_i] = {m_r, m_g, c};
            w_i = (w_i + 1) % 256;
            w_p = 0;
          end
        end
      endcase
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 8'h00, "");
  endtask

  task automatic rreg(input logic [1:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, 8'h00, tag);
  endtask

  task automatic pix(input logic [7:0] idx, input string tag);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, idx, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, "");
  endtask

  task automatic put_entry(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wreg(A_DATA, r); wreg(A_DATA, g); wreg(A_DATA, b);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rreg(A_WIDX, "R1 write pointer");
    rreg(A_RIDX, "R1 read pointer");
    rreg(A_MASK, "R1 mask");
    rreg(A_DATA, "R1 red phase");   // consumes red of entry 0 (contents unknown to model)
    idle(2);
    // Re-sync read cursor with model
    wreg(A_RIDX, 8'd0);

    // R2, R4: fill entries 0..3, high bits set on purpose
    wreg(A_WIDX, 8'd0);
    for (int i = 0; i < 4; i++)
      put_entry(8'(8'hC0 | (i*9+1)), 8'(8'h80 | (i*11+2)), 8'(8'h40 | (i*13+3)));
    rreg(A_WIDX, "R5 pointer after 4 triplets");

    // R6, R7: read back entries 0 and 1, component by component
    wreg(A_RIDX, 8'd0);
    for (int i = 0; i < 6; i++) rreg(A_DATA, "R7 data read");
    rreg(A_RIDX, "R6 read pointer advanced");

    // R6: reload mid-triplet returns to red
    wreg(A_RIDX, 8'd1);
    rreg(A_DATA, "R6 red before reload");
    wreg(A_RIDX, 8'd1);
    rreg(A_DATA, "R6 red after reload");
    rreg(A_DATA, "R6 green after reload");

    // R3, R4: abandoned triplet leaves entry 2 unchanged
    wreg(A_WIDX, 8'd2);
    wreg(A_DATA, 8'h3F);
    wreg(A_DATA, 8'h2A);
    wreg(A_WIDX, 8'd2);
    rreg(A_WIDX, "R3 pointer reloaded");
    pix(8'd2, "R4 partial triplet not committed");
    // R3: the reload restarted at red
    put_entry(8'h05, 8'h06, 8'h07);
    pix(8'd2, "R3 phase reset to red");

    // R5: wrap from 255 to 0
    wreg(A_WIDX, 8'd254);
    for (int i = 0; i < 3; i++) put_entry(8'(i+20), 8'(i+30), 8'(i+40));
    rreg(A_WIDX, "R5 wrap past 255");

    // R8, R9: lookups with open mask
    for (int i = 0; i < 4; i++) pix(8'(i), "R9 pixel lookup");
    pix(8'd255, "R9 pixel lookup top");
    wreg(A_MASK, 8'h0F);
    rreg(A_MASK, "R8 mask readback");
    pix(8'hF1, "R8 masked lookup");
    pix(8'h13, "R8 masked lookup");
    wreg(A_MASK, 8'hFF);
    pix(8'h00, "R8 open mask after restore");

    // R9: commit and lookup of the same entry on one edge
    wreg(A_WIDX, 8'd20);
    put_entry(8'h11, 8'h12, 8'h13);
    wreg(A_WIDX, 8'd20);
    wreg(A_DATA, 8'h21);
    wreg(A_DATA, 8'h22);
    step(1'b1, 1'b0, A_DATA, 8'h23, 1'b1, 8'd20, "R9 old colour during commit");
    pix(8'd20, "R9 new colour after commit");

    // R5: full sweep of 256 entries from 0
    wreg(A_WIDX, 8'd0);
    for (int i = 0; i < 256; i++) put_entry(8'(i*7), 8'(i*3+1), 8'(255-i));
    rreg(A_WIDX, "R5 256 triplets wrap to 0");
    wreg(A_RIDX, 8'd250);
    for (int i = 0; i < 18; i++) rreg(A_DATA, "R6 sweep readback");
    rreg(A_RIDX, "R6 read pointer wrapped");
    for (int i = 0; i < 8; i++) pix(8'(i*37), "R9 sweep lookup");

    idle(4);
    if (bus_q.size() != 0 || pix_q.size() != 0) begin
      n_bad++;
      $display("FAIL drain: pending actual %0d expected 0", bus_q.size() + pix_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // R1 data-phase read above has an unknown result; drop it from the scoreboard
  initial begin
    @(negedge rst);
    wait (bus_q.size() == 4);
    void'(bus_q.pop_back());
  end

endmodule